// File: doc/BRIEF.md
# Conditional Branch and Subroutine Unit

This unit resolves control-transfer instructions for a 32-bit processor core. It receives an instruction word, the current program counter, the four condition flags (negative, zero, carry, overflow) and the word that follows the instruction in memory. It then decides whether control leaves the sequential path and produces the next program counter. For the two call forms it also produces the return address and a strobe that writes the link register.

The unit recognises words whose top three bits are `001`. The five bits below them select a condition: sixteen flag tests, an absolute call or a PC-relative call. The low 24 bits hold a signed word count that is scaled by four. One value of that field, the most negative one, means that the displacement or target is in the following 32-bit word. The unit raises a flag when it uses that word, so the fetch stage can skip over it. Results are registered: a request strobe samples the inputs, and one clock later the outputs carry the result with a valid pulse.

Top module: `brsub_unit`

## Requirements
- R1: Only a word with bits [31:29] = 3'b001 and bits [28:24] in 0x00..0x11 is a control transfer and raises `is_branch`. Any other word gives `is_branch`=0, `taken`=0, `link_we`=0, `ext_used`=0 and `next_pc` = pc+4.
- R2: A request with `in_valid`=1 is sampled on a rising clock edge. Its results appear on the outputs after that edge, together with a one-cycle `out_valid` pulse. Without a request, all result outputs hold their values. While reset is active and after it is released, all outputs are zero.
- R3: Code 0x20 (bits [28:24]=0x00) is never taken. Code 0x21 is always taken.
- R4: Codes 0x22..0x29 are taken on, in turn: Z, !Z, C, !C, V, !V, N, !N.
- R5: Carry means a borrow occurred. Code 0x2A (unsigned lower-or-same) is taken on C|Z. Code 0x2B (unsigned higher) is taken on !C&!Z.
- R6: Code 0x2C is taken on N^V and code 0x2D on its complement. Code 0x2E is taken on (N^V)|Z and code 0x2F on its complement.
- R7: A relative target is the sequential address plus the sign-extended 24-bit field times 4. The sequential address is pc+4, and the sum wraps at 32 bits.
- R8: A 24-bit field equal to 0x800000 sets `ext_used`. The sequential address then becomes pc+8, and `ext_word` replaces the scaled field value.
- R9: Code 0x30 is always taken to the absolute address given by the sign-extended field times 4, or by `ext_word` when the field is 0x800000. It raises `link_we` with `link_val` set to the sequential address.
- R10: Code 0x31 is always taken to a relative target as in R7/R8. It raises `link_we` with `link_val` set to the sequential address.
- R11: A transfer that is not taken gives `next_pc` equal to the sequential address, which includes the skip over an extension word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; samples the inputs below |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry (borrow) flag |
| flag_v | input | 1 | Overflow flag |
| ext_word | input | 32 | Word following the instruction |
| out_valid | output | 1 | One-cycle result strobe |
| is_branch | output | 1 | Word was a recognised control transfer |
| taken | output | 1 | Control leaves the sequential path |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Write strobe for the link register |
| link_val | output | 32 | Return address |
| ext_used | output | 1 | The following word was used |

## Verification
Each flag test is run with one flag combination that takes the branch and one that does not. The compound signed and unsigned tests are also run with the single flag that flips them, which separates, for example, C|Z from C alone and N^V from N. Offsets are driven as positive, negative, the most negative encodable value and the sentinel. The sentinel is applied to conditional, absolute and relative forms, and this shows whether the extension word is used as a displacement or as an address and whether the sequential skip becomes 8. Non-branch and reserved codes, a program counter that wraps, and idle cycles between requests check classification and output holding.

// File: rtl/brsub_pkg.sv
package brsub_pkg;

  // Instruction class in bits [31:29]
  localparam logic [2:0] CLASS_XFER = 3'b001;

  // Selector values in bits [28:24]
  localparam logic [4:0] SEL_CALL_ABS = 5'h10;
  localparam logic [4:0] SEL_CALL_REL = 5'h11;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_COND    = 2'd1,
    KIND_CALLABS = 2'd2,
    KIND_CALLREL = 2'd3
  } xfer_kind_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/brsub_decode.sv
module brsub_decode
  import brsub_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int OFS_W  = 24
) (
  input  logic [INSN_W-1:0] instr,
  output xfer_kind_t        kind,
  output logic [3:0]        cond,
  output logic [OFS_W-1:0]  field,
  output logic              sentinel
);
  localparam int SEL_LSB = OFS_W;
  localparam logic [OFS_W-1:0] SENT_VAL = {1'b1, {(OFS_W-1){1'b0}}};

  logic [2:0] cls;
  logic [4:0] sel;

  always_comb begin
    cls      = instr[INSN_W-1 -: 3];
    sel      = instr[SEL_LSB +: 5];
    field    = instr[OFS_W-1:0];
    cond     = sel[3:0];
    sentinel = (field == SENT_VAL);
    kind     = KIND_NONE;
    if (cls == CLASS_XFER) begin
      if (!sel[4])                  kind = KIND_COND;
      else if (sel == SEL_CALL_ABS) kind = KIND_CALLABS;
      else if (sel == SEL_CALL_REL) kind = KIND_CALLREL;
      else                          kind = KIND_NONE;
    end
  end

endmodule

// File: rtl/brsub_cond_eval.sv
module brsub_cond_eval
  import brsub_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] cond,
  output logic       pass
);
  // Each even code is a base test; the following odd code is its complement.
  logic [7:0] base;
  logic       lt_s;

  always_comb begin
    lt_s    = flags.n ^ flags.v;
    base[0] = 1'b0;
    base[1] = flags.z;
    base[2] = flags.c;
    base[3] = flags.v;
    base[4] = flags.n;
    base[5] = flags.c | flags.z;
    base[6] = lt_s;
    base[7] = lt_s | flags.z;
    pass    = base[cond[3:1]] ^ cond[0];
  end

endmodule

// File: rtl/brsub_target.sv
module brsub_target
  import brsub_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFS_W    = 24,
  parameter int SCALE_SH = 2,
  parameter int INSN_W   = 32
) (
  input  xfer_kind_t        kind,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFS_W-1:0]  field,
  input  logic              sentinel,
  input  logic [ADDR_W-1:0] ext_word,
  output logic              ext_used,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] target
);
  localparam int INSN_BYTES = INSN_W / 8;
  localparam int PAD_W      = ADDR_W - OFS_W - SCALE_SH;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    ext_used = (kind != KIND_NONE) && sentinel;
    step     = ext_used ? ADDR_W'(2 * INSN_BYTES) : ADDR_W'(INSN_BYTES);
    seq_pc   = pc + step;
    scaled   = {{PAD_W{field[OFS_W-1]}}, field, {SCALE_SH{1'b0}}};
    disp     = ext_used ? ext_word : scaled;
    if (kind == KIND_CALLABS) target = disp;
    else                      target = seq_pc + disp;
  end

endmodule

// File: rtl/brsub_unit.sv
module brsub_unit
  import brsub_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INSN_W   = 32,
  parameter int OFS_W    = 24,
  parameter int SCALE_SH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] instr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic [ADDR_W-1:0] ext_word,
  output logic              out_valid,
  output logic              is_branch,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val,
  output logic              ext_used
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  xfer_kind_t        kind;
  logic [3:0]        cond;
  logic [OFS_W-1:0]  field;
  logic              sentinel;
  logic              cond_pass;
  logic              ext_hit;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] target;
  flags_t            flags;

  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  brsub_decode #(.INSN_W(INSN_W), .OFS_W(OFS_W)) u_decode (
    .instr    (instr),
    .kind     (kind),
    .cond     (cond),
    .field    (field),
    .sentinel (sentinel)
  );

  brsub_cond_eval u_cond (
    .flags (flags),
    .cond  (cond),
    .pass  (cond_pass)
  );

  brsub_target #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SCALE_SH(SCALE_SH), .INSN_W(INSN_W)
  ) u_target (
    .kind     (kind),
    .pc       (pc),
    .field    (field),
    .sentinel (sentinel),
    .ext_word (ext_word),
    .ext_used (ext_hit),
    .seq_pc   (seq_pc),
    .target   (target)
  );

  // Next-state logic
  logic              nx_isbr;
  logic              nx_taken;
  logic [ADDR_W-1:0] nx_pc;
  logic              nx_lwe;
  logic              res_en;

  always_comb begin
    res_en  = in_valid;
    nx_isbr = (kind != KIND_NONE);
    nx_lwe  = (kind == KIND_CALLABS) || (kind == KIND_CALLREL);
    unique case (kind)
      KIND_COND:                  nx_taken = cond_pass;
      KIND_CALLABS, KIND_CALLREL: nx_taken = 1'b1;
      default:                    nx_taken = 1'b0;
    endcase
    nx_pc = nx_taken ? target : seq_pc;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      is_branch <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      link_we   <= 1'b0;
      link_val  <= '0;
      ext_used  <= 1'b0;
    end else if (res_en) begin
      is_branch <= nx_isbr;
      taken     <= nx_taken;
      next_pc   <= nx_pc;
      link_we   <= nx_lwe;
      link_val  <= seq_pc;
      ext_used  <= ext_hit;
    end
  end

endmodule

// File: rtl/brsub_unit_chk.sv
module brsub_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic [ADDR_W-1:0] pc,
  input logic              out_valid,
  input logic              is_branch,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              link_we,
  input logic [ADDR_W-1:0] link_val,
  input logic              ext_used
);
  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(next_pc) && $stable(taken));

  // R1
  non_xfer_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && !is_branch) |-> (!taken && !link_we && !ext_used));

  // R11
  seq_path_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid ##1 !taken) |->
      next_pc == $past(pc) + (ext_used ? ADDR_W'(8) : ADDR_W'(4)));

  // R9
  link_taken_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && link_we) |-> (taken && is_branch));

  // R10
  link_addr_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid ##1 link_we) |->
      link_val == $past(pc) + (ext_used ? ADDR_W'(8) : ADDR_W'(4)));

  // R8
  ext_class_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && ext_used) |-> is_branch);

endmodule

bind brsub_unit brsub_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .in_valid  (in_valid),
  .pc        (pc),
  .out_valid (out_valid),
  .is_branch (is_branch),
  .taken     (taken),
  .next_pc   (next_pc),
  .link_we   (link_we),
  .link_val  (link_val),
  .ext_used  (ext_used)
);

// File: tb/brsub_unit_tb.sv
module brsub_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [31:0] pc;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [31:0] ext_word;
  logic        out_valid, is_branch, taken, link_we, ext_used;
  logic [31:0] next_pc, link_val;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  brsub_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .ext_word(ext_word), .out_valid(out_valid), .is_branch(is_branch),
    .taken(taken), .next_pc(next_pc), .link_we(link_we),
    .link_val(link_val), .ext_used(ext_used)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Row: instr | flags NZCV | ext | is_br | taken | next | lwe | link | extu | req
  localparam int NV = 25;
  localparam logic [143:0] VT [NV] = '{
    {32'h20000010, 4'b0000, 32'h0,        1'b1, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd3},  // R3 never
    {32'h21000010, 4'b0000, 32'h0,        1'b1, 1'b1, 32'h00001044, 1'b0, 32'h0,        1'b0, 8'd3},  // R3 always
    {32'h22000004, 4'b0100, 32'h0,        1'b1, 1'b1, 32'h00001014, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 eq
    {32'h22000004, 4'b0000, 32'h0,        1'b1, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 eq miss
    {32'h23FFFFFF, 4'b0000, 32'h0,        1'b1, 1'b1, 32'h00001000, 1'b0, 32'h0,        1'b0, 8'd7},  // R7 negative
    {32'h24000008, 4'b0010, 32'h0,        1'b1, 1'b1, 32'h00001024, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 cs
    {32'h27000002, 4'b0001, 32'h0,        1'b1, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 vc miss
    {32'h28000002, 4'b1000, 32'h0,        1'b1, 1'b1, 32'h0000100C, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 mi
    {32'h2A000003, 4'b0100, 32'h0,        1'b1, 1'b1, 32'h00001010, 1'b0, 32'h0,        1'b0, 8'd5},  // R5 ule on Z
    {32'h2B000003, 4'b0000, 32'h0,        1'b1, 1'b1, 32'h00001010, 1'b0, 32'h0,        1'b0, 8'd5},  // R5 ugt
    {32'h2B000003, 4'b0010, 32'h0,        1'b1, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd5},  // R5 ugt miss
    {32'h2C000005, 4'b1000, 32'h0,        1'b1, 1'b1, 32'h00001018, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 slt
    {32'h2C000005, 4'b1001, 32'h0,        1'b1, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 slt miss
    {32'h2E000005, 4'b0100, 32'h0,        1'b1, 1'b1, 32'h00001018, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 sle on Z
    {32'h2F000005, 4'b0000, 32'h0,        1'b1, 1'b1, 32'h00001018, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 sgt
    {32'h2D000005, 4'b0001, 32'h0,        1'b1, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 sge miss
    {32'h21800000, 4'b0000, 32'h00000100, 1'b1, 1'b1, 32'h00001108, 1'b0, 32'h0,        1'b1, 8'd8},  // R8 ext disp
    {32'h20800000, 4'b0000, 32'h00000100, 1'b1, 1'b0, 32'h00001008, 1'b0, 32'h0,        1'b1, 8'd11}, // R11 skip ext
    {32'h30000800, 4'b0000, 32'h0,        1'b1, 1'b1, 32'h00002000, 1'b1, 32'h00001004, 1'b0, 8'd9},  // R9 abs
    {32'h30800000, 4'b0000, 32'hCAFE0000, 1'b1, 1'b1, 32'hCAFE0000, 1'b1, 32'h00001008, 1'b1, 8'd9},  // R9 abs ext
    {32'h31000010, 4'b0000, 32'h0,        1'b1, 1'b1, 32'h00001044, 1'b1, 32'h00001004, 1'b0, 8'd10}, // R10 rel
    {32'h31800000, 4'b0000, 32'hFFFFFFF0, 1'b1, 1'b1, 32'h00000FF8, 1'b1, 32'h00001008, 1'b1, 8'd10}, // R10 rel ext
    {32'h40000000, 4'b1111, 32'h0,        1'b0, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd1},  // R1 other class
    {32'h32800000, 4'b0000, 32'h0,        1'b0, 1'b0, 32'h00001004, 1'b0, 32'h0,        1'b0, 8'd1},  // R1 reserved sel
    {32'h23800000, 4'b0100, 32'h00000010, 1'b1, 1'b0, 32'h00001008, 1'b0, 32'h0,        1'b1, 8'd11}  // R11 ne miss ext
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drive one request; results are checked at the negedge after the capturing posedge
  task automatic issue(input logic [31:0] w, input logic [31:0] p,
                       input logic [3:0] f, input logic [31:0] x);
    @(negedge clk);
    instr = w; pc = p; ext_word = x;
    {flag_n, flag_z, flag_c, flag_v} = f;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; pc = '0; ext_word = '0;
    {flag_n, flag_z, flag_c, flag_v} = 4'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset out_valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 post-reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R2 post-reset next_pc", next_pc, 32'd0);
    chk("R2 post-reset flags", {27'b0, is_branch, taken, link_we, ext_used, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [143:0] v;
      string tag;
      v = VT[i];
      tag = $sformatf("R%0d row%0d", v[7:0], i);
      issue(v[143:112], 32'h00001000, v[111:108], v[107:76]);
      chk({tag, " out_valid"}, {31'b0, out_valid}, 32'd1);
      chk({tag, " is_branch"}, {31'b0, is_branch}, {31'b0, v[75]});
      chk({tag, " taken"},     {31'b0, taken},     {31'b0, v[74]});
      chk({tag, " next_pc"},   next_pc,            v[73:42]);
      chk({tag, " link_we"},   {31'b0, link_we},   {31'b0, v[41]});
      if (v[41]) chk({tag, " link_val"}, link_val, v[40:9]);
      chk({tag, " ext_used"},  {31'b0, ext_used},  {31'b0, v[8]});
    end

    // R2: idle cycles hold the last result and drop out_valid
    issue(32'h31000010, 32'h00004000, 4'b0000, 32'h0);
    @(negedge clk);
    chk("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
    chk("R2 hold next_pc", next_pc, 32'h00004044);
    chk("R2 hold link_val", link_val, 32'h00004004);

    // R7: sequential address wraps at 32 bits
    issue(32'h21000000, 32'hFFFFFFFC, 4'b0000, 32'h0);
    chk("R7 wrap next_pc", next_pc, 32'h00000000);

    // R7: most negative encodable offset
    issue(32'h21800001, 32'h02000000, 4'b0000, 32'h0);
    chk("R7 min offset next_pc", next_pc, 32'h00000008);
    chk("R7 min offset ext_used", {31'b0, ext_used}, 32'd0);

    // R2: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R2 async reset next_pc", next_pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: back to normal operation after reset
    issue(32'h21000001, 32'h00000100, 4'b0000, 32'h0);
    chk("R3 after reset next_pc", next_pc, 32'h00000108);

    finish_run();
  end

endmodule